// File: doc/BRIEF.md
# Serial Peripheral Port with Write-Collision Guard

This block is an 8-bit synchronous serial port with a small register window: one control register, one status register and one data register. It runs either as the clock-owning end of the link or as the selected end. Clock polarity and clock phase are programmable. As the clock owner it divides the system clock by one of four ratios to make the serial clock.

The port knows when a transfer is under way, and the rule for that depends on its role and its clock phase. A write to the data register inside that window is refused and flagged. The accepted byte and the transfer keep going unchanged. Transfer completion and a mode fault raise an interrupt request. Software can block that request globally. The block also tells the surrounding port logic which of its four shared pins belong to the serial function, which of them it drives, and whether the whole port drives open-drain.

A mode fault means another device pulled the select line low while this block was the clock owner. The block then hands the bus back by dropping its enable and its master role.

Top module: `spi_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0 in bits 7..2 except bit 2 (clock phase), which reads 1. The status register (address 1) reads 0, irq is 0 and no pin is claimed.
- R2: The rate field, control bits 1..0, keeps the value last written across a reset.
- R3: Control bit 6 enables the port and bit 4 selects the master role. In that state, a data-register write (address 2) sends the byte MSB first on mosi_o. The byte on miso_in is received and can be read from address 2. Status bit 7 (done) sets when the byte is complete.
- R4: In master mode the serial clock rests at the level of control bit 3 between transfers. Its period is 2, 4, 16 or 32 system clocks for rate codes 0, 1, 2 and 3.
- R5: With phase 0 (control bit 2 = 0), each bit is valid before its leading clock edge and is sampled on that edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R6: In master mode a data-register write made between the starting write and the done flag sets status bit 6 (collision). That write is dropped, and the byte sent and the byte received are unaffected.
- R7: A phase-0 slave is busy whenever select (ss_in) is low, including after done has set. A data write then sets the collision flag. Once select is high, the same write is accepted without a collision.
- R8: A phase-1 slave is busy from its first leading clock edge until done. A write in that window sets the collision flag and is dropped. A write after done, with select still low, is accepted without a collision.
- R9: Each status flag clears only when a status read that saw the flag set is followed by a data-register read or write. A data access with no such status read leaves the flag set.
- R10: irq is high exactly when control bit 7 is 1, done or mode fault is set, and irq_mask is 0.
- R11: A mode fault occurs when the port is enabled as master, ss_dir is 0 and ss_in goes low. It sets status bit 4 and clears control bits 6 and 4. With ss_dir at 1, a low ss_in causes no fault.
- R12: Pin index order is 0 = MISO, 1 = MOSI, 2 = SCK, 3 = SS. When enabled, pin_own claims pins 0..2, and pin 3 unless the port is master with ss_dir = 1. pin_oe is 0110 for a master and 0001 for a slave with select low. It is 0 when the port is disabled. open_drain follows control bit 5 regardless of enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read strobe |
| irq_mask | input | 1 | Global interrupt mask |
| ss_dir | input | 1 | Direction bit of the select pin from the port logic |
| ss_in | input | 1 | Select line, active low |
| sck_in | input | 1 | Serial clock in slave mode |
| mosi_in | input | 1 | Serial data in slave mode |
| miso_in | input | 1 | Serial data in master mode |
| sck_o | output | 1 | Serial clock in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_o | output | 1 | Serial data out in slave mode |
| pin_own | output | 4 | Pins handed to the serial function |
| pin_oe | output | 4 | Pins the serial function drives |
| open_drain | output | 1 | Open-drain drive for the whole port |
| irq | output | 1 | Interrupt request |

## Verification
A register read returns its value in the same cycle as the strobe, and a register write takes effect at the next edge. Master clock edges come half a period after the starting write, and each one shows on sck_o one cycle after the edge that caused it. Done sets one cycle after the last clock edge, and the status flag one cycle after that. A collision shows up in status at the first read after the refused write. The bench acts as the peer device and samples every output at the falling clock edge, so it always sees settled values. It polls status only after the last serial edge, so every flag it expects has already arrived.

// File: rtl/spi_pkg.sv
// Shared constants and types for the serial port.
// Assumes an 8-bit register window with a 2-bit address.
package spi_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

    localparam int unsigned SB_DONE = 7;
    localparam int unsigned SB_WCOL = 6;
    localparam int unsigned SB_MODF = 4;

    localparam int unsigned NFLAG = 3;
    localparam int unsigned F_DONE = 0;
    localparam int unsigned F_WCOL = 1;
    localparam int unsigned F_MODF = 2;

    localparam int unsigned PIN_MISO = 0;
    localparam int unsigned PIN_MOSI = 1;
    localparam int unsigned PIN_SCK  = 2;
    localparam int unsigned PIN_SS   = 3;

    // Control bits 7..2, stored with a reset value.
    typedef struct packed {
        logic ie;
        logic en;
        logic od;
        logic mstr;
        logic cpol;
        logic cpha;
    } ctrl_hi_t;

    localparam ctrl_hi_t CTRL_RST = '{ie: 1'b0, en: 1'b0, od: 1'b0,
                                      mstr: 1'b0, cpol: 1'b0, cpha: 1'b1};
endpackage

// File: rtl/spi_rate_div.sv
// Master clock divider: gives a one-cycle tick every half serial period.
// Assumes run drops between transfers so that each transfer starts on a whole half period.
module spi_rate_div #(
    parameter int unsigned DIV0 = 2,
    parameter int unsigned DIV1 = 4,
    parameter int unsigned DIV2 = 16,
    parameter int unsigned DIV3 = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int unsigned CNT_W = $clog2(DIV3 / 2 + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    // Select the half-period count limit for the chosen rate.
    always_comb begin
        case (rate)
            2'd0:    lim = CNT_W'(DIV0 / 2 - 1);
            2'd1:    lim = CNT_W'(DIV1 / 2 - 1);
            2'd2:    lim = CNT_W'(DIV2 / 2 - 1);
            default: lim = CNT_W'(DIV3 / 2 - 1);
        endcase
        tick = run && (cnt_q == lim);
    end

    // Count system clocks within a half period while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_shift_engine.sv
// Bit engine: shift register, edge counter, master clock phase and slave edge detection.
// Assumes sck_in and ss_act are already synchronous to clk. There are 2*W clock edges
// per word, and even counts are leading edges.
module spi_shift_engine #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         mstr,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         abort,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         ss_act,
    input  logic         sck_in,
    input  logic         din,
    output logic         m_run,
    output logic         sck_out,
    output logic         dout,
    output logic         done,
    output logic [W-1:0] rx_data,
    output logic         busy
);
    localparam int unsigned EDGES = 2 * W;
    localparam int unsigned CW    = $clog2(EDGES);
    localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

    logic [W-1:0]  shreg;
    logic          rx_bit, m_act, ph, sck_q, s_busy;
    logic [CW-1:0] ecnt;
    logic          s_lead, s_trail, edge_ev, lead_ev, last_ev, sample_ev, commit_ev;
    logic [W-1:0]  next_word;

    // Classify the current clock edge and form the next shift-register word.
    always_comb begin
        s_lead    = !mstr && ss_act && (sck_q == cpol) && (sck_in != cpol);
        s_trail   = !mstr && ss_act && (sck_q != cpol) && (sck_in == cpol);
        edge_ev   = en && (mstr ? (m_act && tick) : (s_lead || s_trail));
        lead_ev   = !ecnt[0];
        last_ev   = (ecnt == LAST);
        sample_ev = edge_ev && (lead_ev != cpha);
        commit_ev = edge_ev && ((!sample_ev && !(cpha && ecnt == '0)) || (cpha && last_ev));
        next_word = {shreg[W-2:0], cpha ? din : rx_bit};
    end

    // Advance the word on clock edges, accept loads and handle aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0; rx_bit <= 1'b0; m_act <= 1'b0; ph <= 1'b0; sck_q <= 1'b0;
            s_busy <= 1'b0; ecnt <= '0; done <= 1'b0; rx_data <= '0;
        end else begin
            sck_q <= sck_in;
            done  <= 1'b0;
            if (edge_ev) begin
                ecnt <= last_ev ? '0 : ecnt + 1'b1;
                if (sample_ev) rx_bit <= din;
                if (commit_ev) shreg <= next_word;
                if (mstr) ph <= !ph;
                if (last_ev) begin
                    done    <= 1'b1;
                    rx_data <= next_word;
                    m_act   <= 1'b0;
                    s_busy  <= 1'b0;
                end else if (!mstr && cpha && ecnt == '0) begin
                    s_busy <= 1'b1;
                end
            end
            if (!mstr && !ss_act) begin
                ecnt   <= '0;
                s_busy <= 1'b0;
            end
            if (load) begin
                shreg <= load_data;
                if (mstr) begin
                    m_act <= 1'b1;
                    ecnt  <= '0;
                    ph    <= 1'b0;
                end
            end
            if (abort) begin
                m_act <= 1'b0; ph <= 1'b0; s_busy <= 1'b0;
                if (mstr) ecnt <= '0;
            end
        end
    end

    assign m_run   = m_act;
    assign sck_out = cpol ^ ph;
    assign dout    = shreg[W-1];
    assign busy    = en && (mstr ? m_act : (cpha ? s_busy : ss_act));
endmodule

// File: rtl/spi_ctrl.sv
// Serial port top: register window, status flags with read-then-access clearing,
// collision and mode-fault detection, interrupt gating and shared-pin controls.
// Assumes one-cycle bus strobes and that all serial inputs are synchronous to clk.
module spi_ctrl
    import spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_mask,
    input  logic              ss_dir,
    input  logic              ss_in,
    input  logic              sck_in,
    input  logic              mosi_in,
    input  logic              miso_in,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              miso_o,
    output logic [3:0]        pin_own,
    output logic [3:0]        pin_oe,
    output logic              open_drain,
    output logic              irq
);
    ctrl_hi_t          ctl_q;
    logic [1:0]        rate_q;
    logic [NFLAG-1:0]  flag_q, arm_q, flag_set;
    logic              ctrl_wr, stat_rd, data_acc, data_wr;
    logic              fault, eng_busy, eng_done, m_run, tick, dout;
    logic [DATA_W-1:0] rx_data, stat_byte;

    // Decode the register accesses of this cycle.
    always_comb begin
        ctrl_wr  = bus_sel && bus_wr && (bus_addr == A_CTRL);
        stat_rd  = bus_sel && !bus_wr && (bus_addr == A_STAT);
        data_acc = bus_sel && (bus_addr == A_DATA);
        data_wr  = data_acc && bus_wr;
        fault    = ctl_q.en && ctl_q.mstr && !ss_in && !ss_dir;
        flag_set[F_DONE] = eng_done;
        flag_set[F_WCOL] = data_wr && eng_busy;
        flag_set[F_MODF] = fault;
    end

    // Hold control bits 7..2; a mode fault takes the port off the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTRL_RST;
        else begin
            if (ctrl_wr) ctl_q <= ctrl_hi_t'(bus_wdata[7:2]);
            if (fault) begin
                ctl_q.en   <= 1'b0;
                ctl_q.mstr <= 1'b0;
            end
        end
    end

    // Rate bits have no reset value and keep their contents across reset.
    always_ff @(posedge clk) begin
        if (ctrl_wr) rate_q <= bus_wdata[1:0];
    end

    // One set/arm/clear cell per status flag.
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
                arm_q[g]  <= 1'b0;
            end else begin
                if (stat_rd)       arm_q[g] <= flag_q[g];
                else if (data_acc) arm_q[g] <= 1'b0;
                if (flag_set[g])                  flag_q[g] <= 1'b1;
                else if (data_acc && arm_q[g])    flag_q[g] <= 1'b0;
            end
        end
    end

    spi_rate_div u_div (
        .clk(clk), .rst_n(rst_n), .run(m_run), .rate(rate_q), .tick(tick)
    );

    spi_shift_engine #(.W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .mstr(ctl_q.mstr),
        .cpol(ctl_q.cpol), .cpha(ctl_q.cpha), .abort(fault || !ctl_q.en),
        .tick(tick), .load(data_wr && !eng_busy), .load_data(bus_wdata),
        .ss_act(!ss_in), .sck_in(sck_in), .din(ctl_q.mstr ? miso_in : mosi_in),
        .m_run(m_run), .sck_out(sck_o), .dout(dout), .done(eng_done),
        .rx_data(rx_data), .busy(eng_busy)
    );

    // Assemble the status byte and the read mux.
    always_comb begin
        stat_byte          = '0;
        stat_byte[SB_DONE] = flag_q[F_DONE];
        stat_byte[SB_WCOL] = flag_q[F_WCOL];
        stat_byte[SB_MODF] = flag_q[F_MODF];
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                A_CTRL:  bus_rdata = {ctl_q, rate_q};
                A_STAT:  bus_rdata = stat_byte;
                A_DATA:  bus_rdata = rx_data;
                default: bus_rdata = '0;
            endcase
        end
    end

    // Pin ownership, drive direction and interrupt request.
    always_comb begin
        pin_own = '0;
        pin_oe  = '0;
        if (ctl_q.en) begin
            pin_own[PIN_MISO] = 1'b1;
            pin_own[PIN_MOSI] = 1'b1;
            pin_own[PIN_SCK]  = 1'b1;
            pin_own[PIN_SS]   = !(ctl_q.mstr && ss_dir);
            if (ctl_q.mstr) begin
                pin_oe[PIN_MOSI] = 1'b1;
                pin_oe[PIN_SCK]  = 1'b1;
            end else begin
                pin_oe[PIN_MISO] = !ss_in;
            end
        end
        irq = ctl_q.ie && (flag_q[F_DONE] || flag_q[F_MODF]) && !irq_mask;
    end

    assign mosi_o     = dout;
    assign miso_o     = dout;
    assign open_drain = ctl_q.od;
endmodule

// File: rtl/spi_ctrl_chk.sv
// Property checker for spi_ctrl, attached by bind; observes ports and internal nets.
module spi_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic irq_mask,
    input logic en,
    input logic mstr,
    input logic cpol,
    input logic cpha,
    input logic ss_in,
    input logic ss_dir,
    input logic sck_o,
    input logic data_wr,
    input logic busy,
    input logic done,
    input logic f_done,
    input logic f_wcol,
    input logic f_modf
);
    // R3: every completed word raises the done flag next cycle.
    a_r3_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> f_done);

    // R4: an idle master rests its clock at the polarity level.
    a_r4_idle_sck_level: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mstr && !busy) |-> (sck_o == cpol));

    // R6: a data write inside the busy window raises the collision flag.
    a_r6_collision_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> f_wcol);

    // R7: a selected phase-0 slave counts as busy.
    a_r7_ph0_slave_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mstr && !cpha && !ss_in) |-> busy);

    // R10: the global mask always silences the request.
    a_r10_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);

    // R11: a mode fault removes the master role and enable and sets its flag.
    a_r11_fault_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mstr && !ss_in && !ss_dir) |=> (!en && !mstr && f_modf));
endmodule

bind spi_ctrl spi_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .irq_mask(irq_mask),
    .en(ctl_q.en), .mstr(ctl_q.mstr), .cpol(ctl_q.cpol), .cpha(ctl_q.cpha),
    .ss_in(ss_in), .ss_dir(ss_dir), .sck_o(sck_o), .data_wr(data_wr),
    .busy(eng_busy), .done(eng_done),
    .f_done(flag_q[spi_pkg::F_DONE]), .f_wcol(flag_q[spi_pkg::F_WCOL]),
    .f_modf(flag_q[spi_pkg::F_MODF])
);

// File: tb/spi_ctrl_bench.sv
// Bench for spi_ctrl: acts as the peer device in both roles. Random master transfers
// are mixed with directed slave, collision, fault and pin cases.
module spi_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_mask = 1'b0, ss_dir = 1'b0, ss_in = 1'b1;
    logic       sck_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0;
    logic       sck_o, mosi_o, miso_o, open_drain, irq;
    logic [3:0] pin_own, pin_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_ctrl u_spi_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_mask(irq_mask), .ss_dir(ss_dir), .ss_in(ss_in), .sck_in(sck_in),
        .mosi_in(mosi_in), .miso_in(miso_in), .sck_o(sck_o), .mosi_o(mosi_o),
        .miso_o(miso_o), .pin_own(pin_own), .pin_oe(pin_oe),
        .open_drain(open_drain), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_period(input logic [1:0] r);
        case (r)
            2'd0: return 2;
            2'd1: return 4;
            2'd2: return 16;
            default: return 32;
        endcase
    endfunction

    function automatic logic [7:0] ctrl_byte(input bit ie, input bit en, input bit od,
                                             input bit ms, input bit pol, input bit pha,
                                             input logic [1:0] r);
        return {ie, en, od, ms, pol, pha, r};
    endfunction

    function automatic logic [7:0] stat_exp(input bit d, input bit w, input bit m);
        return {d, w, 1'b0, m, 4'b0000};
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One master transfer with the bench as the peer; optionally a colliding write.
    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sb, input logic [1:0] r,
                               input bit pol, input bit pha, input bit ie, input bit collide);
        logic [7:0] cap, rd;
        logic prev, mq;
        int leads, trails, cyc, t0, t1;
        bit hit;
        cap = 8'd0; leads = 0; trails = 0; cyc = 0; t0 = 0; t1 = 0; hit = 0;
        ss_in = 1'b1;
        bus_write(2'd0, ctrl_byte(ie, 1, 0, 1, pol, pha, r));
        miso_in = sb[7];
        bus_write(2'd2, tx);
        prev = sck_o; mq = mosi_o;
        for (int k = 0; k < 2000 && trails < 8; k++) begin
            @(negedge clk);
            cyc++;
            bus_sel = 1'b0; bus_wr = 1'b0;
            if (sck_o != prev) begin
                if (sck_o != pol) begin
                    if (leads == 0) t0 = cyc;
                    if (leads == 1) t1 = cyc;
                    if (!pha) cap = {cap[6:0], mq};
                    else miso_in = sb[7 - leads];
                    leads++;
                end else begin
                    if (pha) cap = {cap[6:0], mq};
                    else if (trails < 7) miso_in = sb[6 - trails];
                    trails++;
                end
            end
            prev = sck_o; mq = mosi_o;
            if (collide && !hit && leads == 3) begin
                hit = 1;
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = ~tx;
            end
        end
        bus_read(2'd1, rd);
        chk("R3/R6 status after transfer", rd, stat_exp(1, collide, 0));
        chk("R10 irq on done", irq, ie && !irq_mask);
        chk("R3/R5 mosi byte", cap, tx);
        chk("R4 sck period", t1 - t0, exp_period(r));
        chk("R4 sck idle level", sck_o, pol);
        bus_read(2'd2, rd);
        chk("R3/R5/R6 received byte", rd, sb);
        bus_read(2'd1, rd);
        chk("R9 flags cleared", rd, 8'h00);
    endtask

    // Bench-driven slave transfer; returns the byte seen on miso_o.
    task automatic slave_bits(input logic [7:0] mb, input bit pol, input bit pha,
                              input bit collide, output logic [7:0] cap);
        cap = 8'd0;
        for (int i = 0; i < 8; i++) begin
            if (!pha) begin
                mosi_in = mb[7 - i];
                cap = {cap[6:0], miso_o};
                repeat (2) @(negedge clk);
                sck_in = !pol;
                repeat (2) @(negedge clk);
                sck_in = pol;
                repeat (2) @(negedge clk);
            end else begin
                sck_in = !pol;
                repeat (2) @(negedge clk);
                mosi_in = mb[7 - i];
                cap = {cap[6:0], miso_o};
                if (collide && i == 0) bus_write(2'd2, 8'h3C);
                else repeat (2) @(negedge clk);
                sck_in = pol;
                repeat (2) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, cap;
        void'($urandom(32'h5EED_1A2B));
        do_reset();

        // R1 reset state
        bus_read(2'd0, rd);
        chk("R1 control reset", {24'd0, rd[7:2]}, 6'b000001);
        bus_read(2'd1, rd);
        chk("R1 status reset", rd, 8'h00);
        chk("R1 irq reset", irq, 1'b0);
        chk("R1 pins reset", pin_own, 4'b0000);

        // R2 rate bits survive reset
        bus_write(2'd0, 8'h02);
        do_reset();
        bus_read(2'd0, rd);
        chk("R2 rate kept", rd, 8'h06);

        // R12 open-drain independent of enable
        bus_write(2'd0, 8'h20);
        chk("R12 open drain", open_drain, 1'b1);
        chk("R12 no pins when off", pin_own, 4'b0000);

        // R12 master pin controls
        ss_dir = 1'b0;
        bus_write(2'd0, ctrl_byte(0, 1, 0, 1, 0, 0, 2'd0));
        chk("R12 master owns all", pin_own, 4'b1111);
        chk("R12 master drives", pin_oe, 4'b0110);
        ss_dir = 1'b1;
        #1 chk("R12 ss as gpio", pin_own, 4'b0111);
        ss_dir = 1'b0;

        // R3 R4 R5 R6 R10 random master transfers, rate 0 and 3 forced once
        for (int n = 0; n < 24; n++) begin
            logic [1:0] r;
            r = (n == 0) ? 2'd0 : (n == 1) ? 2'd3 : 2'($urandom_range(0, 3));
            irq_mask = 1'($urandom_range(0, 1));
            master_xfer(8'($urandom), 8'($urandom), r, 1'($urandom_range(0, 1)),
                        1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                        (n % 3) == 2);
        end
        irq_mask = 1'b0;

        // R7 phase-0 slave
        for (int p = 0; p < 2; p++) begin
            ss_in = 1'b1;
            sck_in = p[0];
            bus_write(2'd0, ctrl_byte(0, 1, 0, 0, p[0], 0, 2'd0));
            bus_write(2'd2, 8'hA7);
            @(negedge clk);
            ss_in = 1'b0;
            repeat (2) @(negedge clk);
            chk("R12 slave drives miso", pin_oe, 4'b0001);
            slave_bits(8'h5C, p[0], 0, 0, cap);
            chk("R7 slave sends byte", cap, 8'hA7);
            bus_write(2'd2, 8'h11);
            bus_read(2'd2, rd);
            chk("R7 slave received", rd, 8'h5C);
            bus_read(2'd1, rd);
            chk("R7/R9 collision after done, no early clear", rd, stat_exp(1, 1, 0));
            bus_read(2'd2, rd);
            bus_read(2'd1, rd);
            chk("R9 cleared by read then access", rd, 8'h00);
            ss_in = 1'b1;
            repeat (2) @(negedge clk);
            bus_write(2'd2, 8'h22);
            bus_read(2'd1, rd);
            chk("R7 write with select high", rd, 8'h00);
        end

        // R8 phase-1 slave
        ss_in = 1'b1;
        sck_in = 1'b1;
        bus_write(2'd0, ctrl_byte(0, 1, 0, 0, 1, 1, 2'd0));
        bus_write(2'd2, 8'h96);
        @(negedge clk);
        ss_in = 1'b0;
        repeat (2) @(negedge clk);
        slave_bits(8'hE1, 1, 1, 1, cap);
        chk("R8 colliding write dropped", cap, 8'h96);
        bus_read(2'd1, rd);
        chk("R8 collision flagged", rd, stat_exp(1, 1, 0));
        bus_read(2'd2, rd);
        chk("R8 slave received", rd, 8'hE1);
        bus_write(2'd2, 8'h5A);
        bus_read(2'd1, rd);
        chk("R8 write after done accepted", rd, 8'h00);
        ss_in = 1'b1;

        // R11 mode fault
        ss_dir = 1'b0;
        bus_write(2'd0, ctrl_byte(1, 1, 0, 1, 0, 1, 2'd1));
        ss_in = 1'b0;
        repeat (2) @(negedge clk);
        bus_read(2'd0, rd);
        chk("R11 enable and master cleared", rd, ctrl_byte(1, 0, 0, 0, 0, 1, 2'd1));
        bus_read(2'd1, rd);
        chk("R11 fault flag", rd, stat_exp(0, 0, 1));
        chk("R10 irq on fault", irq, 1'b1);
        irq_mask = 1'b1;
        #1 chk("R10 mask", irq, 1'b0);
        irq_mask = 1'b0;
        bus_read(2'd2, rd);
        bus_read(2'd1, rd);
        chk("R9 fault cleared", rd, 8'h00);
        ss_in = 1'b1;
        ss_dir = 1'b1;
        bus_write(2'd0, ctrl_byte(0, 1, 0, 1, 0, 1, 2'd1));
        ss_in = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(2'd1, rd);
        chk("R11 no fault with ss as output", rd, 8'h00);
        bus_read(2'd0, rd);
        chk("R11 control unchanged", rd, ctrl_byte(0, 1, 0, 1, 0, 1, 2'd1));
        ss_in = 1'b1;

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule